// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block sits next to a UART shifter and turns its status events into sticky flags. It combines those flags with software enable bits to drive three interrupt lines: transmit, receive and flow control. Each flag is set by a one-cycle event pulse from the datapath. It is cleared as a side effect of the one bus access that services it: a transmit buffer write, a receive buffer read, a status read or an interrupt control read.

For transfers without the processor, the block also raises one-cycle DMA request pulses. A pulse goes out when the transmit-empty or receive-full flag goes from clear to set. Turning on a DMA channel takes the matching buffer source out of the interrupt path, so the DMA engine services the buffer instead of the processor. The error summary flag ORs a parameterized number of error sources. The asynchronous active-low reset is released through a synchronizer.

Top module: `uart_irq_dma_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, the transmit-empty flag is set and the receive-full, error and clear-to-send-change flags are clear. No DMA request follows reset release, even with transmit DMA enabled.
- R2: `irq_tx` is high when the transmit-empty flag and `en_tx_irq` are both set and `en_tx_dma` is low. A `wr_txbuf` strobe clears the transmit-empty flag at the next clock edge.
- R3: `irq_rx` is high when the receive-full flag and `en_rx_irq` are both set and `en_rx_dma` is low. A `rd_rxbuf` strobe clears the receive-full flag.
- R4: A pulse on any bit of `ev_err` (framing, overrun and parity sources, one bit each) sets the summary error flag. With `en_err_irq` set, that flag raises `irq_rx`. A `rd_status` strobe clears it.
- R5: `irq_fc` is high when the clear-to-send-change flag and `en_fc_irq` are both set. A `rd_ictrl` strobe clears that flag.
- R6: When a set event and the clearing strobe for the same flag occur in the same cycle, the flag ends up set.
- R7: With `en_tx_dma` set, a clear-to-set change of the transmit-empty flag gives exactly one cycle of `dma_tx_req`. The pulse comes in the cycle after the event edge. A further event while the flag is already set gives no pulse.
- R8: While `en_tx_dma` is set, `irq_tx` stays low whatever `en_tx_irq` holds.
- R9: With `en_rx_dma` set, a clear-to-set change of the receive-full flag gives exactly one cycle of `dma_rx_req`. Both DMA requests can pulse in the same cycle.
- R10: While `en_rx_dma` is set, the receive-full source no longer raises `irq_rx`, but the error source still does.
- R11: Clearing an enable bit drops its interrupt without changing the flag, so setting the bit again brings the interrupt back.
- R12: Each clearing strobe affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_empty | input | 1 | Pulse: transmit buffer became empty |
| ev_rx_full | input | 1 | Pulse: receive buffer became full |
| ev_err | input | NUM_ERR | Pulses: framing, overrun, parity errors |
| ev_cts_chg | input | 1 | Pulse: clear-to-send line changed |
| wr_txbuf | input | 1 | Strobe: transmit buffer write |
| rd_rxbuf | input | 1 | Strobe: receive buffer read |
| rd_status | input | 1 | Strobe: status register read |
| rd_ictrl | input | 1 | Strobe: interrupt control register read |
| en_tx_irq | input | 1 | Transmit interrupt enable |
| en_rx_irq | input | 1 | Receive-full interrupt enable |
| en_err_irq | input | 1 | Error interrupt enable |
| en_fc_irq | input | 1 | Flow control interrupt enable |
| en_tx_dma | input | 1 | Transmit DMA enable |
| en_rx_dma | input | 1 | Receive DMA enable |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_fc | output | 1 | Flow control interrupt |
| dma_tx_req | output | 1 | Transmit DMA request pulse |
| dma_rx_req | output | 1 | Receive DMA request pulse |

## Verification
The bench builds the block with `NUM_ERR` = 3 and `SYNC_STAGES` = 2. Three error inputs let the bench pulse each source on its own and show that any one of them sets the shared summary flag and that one status read clears it. Two synchronizer stages fix a known lag after reset release. The bench waits out that lag before its first stimulus, and then confirms that no stray DMA request appears when transmit DMA is enabled on a flag that reset left set.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NFLAG = 4;
  localparam int NDMA  = 2;

  // Flag slots; the order selects reset values and DMA channels.
  typedef enum logic [1:0] {
    FLG_TBE = 2'd0,
    FLG_RBF = 2'd1,
    FLG_ERR = 2'd2,
    FLG_CTS = 2'd3
  } flag_e;

  // Only the transmit-empty flag comes out of reset set.
  function automatic logic flag_rst_val(input int idx);
    return (idx == int'(FLG_TBE));
  endfunction

endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic upd_en;

  // The set event is applied last, so it wins over a clear in the same cycle.
  always_comb begin
    upd_en = set_i | clr_i;
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
    end else if (upd_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/uart_dma_edge.sv
module uart_dma_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic en_i,
  output logic req_o
);

  logic shadow_q;

  // The shadow copy resets to the flag's own reset value, so reset makes no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
    end else begin
      shadow_q <= flag_i;
    end
  end

  assign req_o = en_i & flag_i & ~shadow_q;

endmodule

// File: rtl/uart_irq_dma_ctl.sv
module uart_irq_dma_ctl
  import uart_irq_pkg::*;
#(
  parameter int NUM_ERR     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_tx_empty,
  input  logic               ev_rx_full,
  input  logic [NUM_ERR-1:0] ev_err,
  input  logic               ev_cts_chg,
  input  logic               wr_txbuf,
  input  logic               rd_rxbuf,
  input  logic               rd_status,
  input  logic               rd_ictrl,
  input  logic               en_tx_irq,
  input  logic               en_rx_irq,
  input  logic               en_err_irq,
  input  logic               en_fc_irq,
  input  logic               en_tx_dma,
  input  logic               en_rx_dma,
  output logic               irq_tx,
  output logic               irq_rx,
  output logic               irq_fc,
  output logic               dma_tx_req,
  output logic               dma_rx_req
);

  logic             rst_sync_n;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flag_q;
  logic [NDMA-1:0]  dma_en;
  logic [NDMA-1:0]  dma_req;

  uart_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Each flag is paired with the one bus access that clears it.
  always_comb begin
    set_vec          = '0;
    clr_vec          = '0;
    set_vec[FLG_TBE] = ev_tx_empty;
    clr_vec[FLG_TBE] = wr_txbuf;
    set_vec[FLG_RBF] = ev_rx_full;
    clr_vec[FLG_RBF] = rd_rxbuf;
    set_vec[FLG_ERR] = |ev_err;
    clr_vec[FLG_ERR] = rd_status;
    set_vec[FLG_CTS] = ev_cts_chg;
    clr_vec[FLG_CTS] = rd_ictrl;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uart_irq_flag #(
      .RST_VAL(flag_rst_val(g))
    ) u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .flag_o(flag_q[g])
    );
  end

  // DMA channel 0 follows the transmit-empty flag, channel 1 the receive-full flag.
  assign dma_en = {en_rx_dma, en_tx_dma};

  for (genvar c = 0; c < NDMA; c++) begin : g_dma
    uart_dma_edge #(
      .RST_VAL(flag_rst_val(c))
    ) u_edge (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .flag_i(flag_q[c]),
      .en_i  (dma_en[c]),
      .req_o (dma_req[c])
    );
  end

  assign dma_tx_req = dma_req[0];
  assign dma_rx_req = dma_req[1];

  // A DMA enable takes the matching buffer source out of the interrupt path.
  always_comb begin
    irq_tx = flag_q[FLG_TBE] & en_tx_irq & ~en_tx_dma;
    irq_rx = (flag_q[FLG_RBF] & en_rx_irq & ~en_rx_dma)
           | (flag_q[FLG_ERR] & en_err_irq);
    irq_fc = flag_q[FLG_CTS] & en_fc_irq;
  end

endmodule

// File: rtl/uart_irq_dma_chk.sv
module uart_irq_dma_chk
  import uart_irq_pkg::*;
#(
  parameter int NUM_ERR = 3
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               ev_tx_empty,
  input logic               ev_rx_full,
  input logic [NUM_ERR-1:0] ev_err,
  input logic               ev_cts_chg,
  input logic               wr_txbuf,
  input logic               rd_ictrl,
  input logic               en_tx_dma,
  input logic               en_fc_irq,
  input logic               irq_tx,
  input logic               irq_fc,
  input logic               dma_tx_req,
  input logic               dma_rx_req,
  input logic [NFLAG-1:0]   flag_q
);

  assert_txclr_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_txbuf && !ev_tx_empty) |=> !flag_q[FLG_TBE]);

  assert_errset_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ev_err) |=> flag_q[FLG_ERR]);

  assert_fcen_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_fc |-> en_fc_irq);

  assert_setwins_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_cts_chg && rd_ictrl) |=> flag_q[FLG_CTS]);

  assert_rxset_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ev_rx_full |=> flag_q[FLG_RBF]);

  assert_txpulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_tx_req |=> !dma_tx_req);

  assert_txedge_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_tx_req |-> !$past(flag_q[FLG_TBE]));

  assert_txoff_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_tx_dma |-> !irq_tx);

  assert_rxpulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_rx_req |=> !dma_rx_req);

endmodule

bind uart_irq_dma_ctl uart_irq_dma_chk #(.NUM_ERR(NUM_ERR)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ev_tx_empty(ev_tx_empty),
  .ev_rx_full (ev_rx_full),
  .ev_err     (ev_err),
  .ev_cts_chg (ev_cts_chg),
  .wr_txbuf   (wr_txbuf),
  .rd_ictrl   (rd_ictrl),
  .en_tx_dma  (en_tx_dma),
  .en_fc_irq  (en_fc_irq),
  .irq_tx     (irq_tx),
  .irq_fc     (irq_fc),
  .dma_tx_req (dma_tx_req),
  .dma_rx_req (dma_rx_req),
  .flag_q     (flag_q)
);

// File: tb/uart_irq_dma_ctl_test.sv
module uart_irq_dma_ctl_test;

  localparam int NVEC = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_tx_empty, ev_rx_full, ev_cts_chg;
  logic [2:0] ev_err;
  logic       wr_txbuf, rd_rxbuf, rd_status, rd_ictrl;
  logic       en_tx_irq, en_rx_irq, en_err_irq, en_fc_irq, en_tx_dma, en_rx_dma;
  logic       irq_tx, irq_rx, irq_fc, dma_tx_req, dma_rx_req;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_dma_ctl #(.NUM_ERR(3), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full), .ev_err(ev_err),
    .ev_cts_chg(ev_cts_chg),
    .wr_txbuf(wr_txbuf), .rd_rxbuf(rd_rxbuf), .rd_status(rd_status), .rd_ictrl(rd_ictrl),
    .en_tx_irq(en_tx_irq), .en_rx_irq(en_rx_irq), .en_err_irq(en_err_irq),
    .en_fc_irq(en_fc_irq), .en_tx_dma(en_tx_dma), .en_rx_dma(en_rx_dma),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_fc(irq_fc),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  // Fields: events {tx,rx,err2,err1,err0,cts}, strobes {wtx,rrx,rst,ric},
  // enables {tx,rx,err,fc,txdma,rxdma}, expected {irq_tx,irq_rx,irq_fc,dtx,drx}.
  localparam logic [20:0] VEC [NVEC] = '{
    {6'b000000, 4'b0000, 6'b100000, 5'b10000},
    {6'b000000, 4'b1000, 6'b100000, 5'b00000},
    {6'b100000, 4'b0000, 6'b100000, 5'b10000},
    {6'b000000, 4'b1000, 6'b100010, 5'b00000},
    {6'b100000, 4'b0000, 6'b100010, 5'b00010},
    {6'b000000, 4'b0000, 6'b100010, 5'b00000},
    {6'b100000, 4'b0000, 6'b100010, 5'b00000},
    {6'b000000, 4'b0000, 6'b100000, 5'b10000},
    {6'b010000, 4'b0000, 6'b010000, 5'b01000},
    {6'b000000, 4'b0000, 6'b000000, 5'b00000},
    {6'b000000, 4'b0000, 6'b010000, 5'b01000},
    {6'b000000, 4'b0100, 6'b010000, 5'b00000},
    {6'b010000, 4'b0100, 6'b010000, 5'b01000},
    {6'b000000, 4'b0100, 6'b010001, 5'b00000},
    {6'b010000, 4'b0000, 6'b010001, 5'b00001},
    {6'b000000, 4'b0000, 6'b010001, 5'b00000},
    {6'b000000, 4'b0100, 6'b000000, 5'b00000},
    {6'b000100, 4'b0000, 6'b001000, 5'b01000},
    {6'b000000, 4'b0000, 6'b011001, 5'b01000},
    {6'b000000, 4'b0010, 6'b001000, 5'b00000},
    {6'b001000, 4'b0010, 6'b001000, 5'b01000},
    {6'b000000, 4'b0010, 6'b001000, 5'b00000},
    {6'b000010, 4'b0000, 6'b000000, 5'b00000},
    {6'b000000, 4'b0000, 6'b001000, 5'b01000},
    {6'b000000, 4'b0010, 6'b001000, 5'b00000},
    {6'b000001, 4'b0000, 6'b000100, 5'b00100},
    {6'b000000, 4'b1110, 6'b000100, 5'b00100},
    {6'b000000, 4'b0001, 6'b000100, 5'b00000},
    {6'b000001, 4'b0001, 6'b000100, 5'b00100},
    {6'b000000, 4'b0001, 6'b000100, 5'b00000},
    {6'b110000, 4'b0000, 6'b000011, 5'b00011},
    {6'b000000, 4'b0000, 6'b000011, 5'b00000}
  };

  string tag [NVEC];

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: outputs {itx,irx,ifc,dtx,drx} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] stim);
    {ev_tx_empty, ev_rx_full, ev_err, ev_cts_chg} = stim[15:10];
    {wr_txbuf, rd_rxbuf, rd_status, rd_ictrl}     = stim[9:6];
    {en_tx_irq, en_rx_irq, en_err_irq, en_fc_irq, en_tx_dma, en_rx_dma} = stim[5:0];
  endtask

  function automatic logic [4:0] outs();
    return {irq_tx, irq_rx, irq_fc, dma_tx_req, dma_rx_req};
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tag = '{"R1","R2","R2","R2","R7","R7","R7","R11",
            "R3","R11","R11","R3","R6","R3","R10","R9",
            "R3","R4","R10","R4","R6","R4","R11","R4",
            "R4","R5","R12","R5","R6","R5","R9","R9"};
    drive(16'h0000);
    repeat (3) @(negedge clk);
    // R1: outputs low while reset is asserted
    check("R1", outs(), 5'b00000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", outs(), 5'b00000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][20:5]);
      @(posedge clk);
      #2;
      check(tag[i], outs(), VEC[i][4:0]);
      @(negedge clk);
    end

    // R1: reset in the middle of a run restores flag reset values.
    drive({6'b010011, 4'b0000, 6'b000000});
    @(posedge clk);
    @(negedge clk);
    drive({6'b000000, 4'b0000, 6'b111100});
    #2;
    check("R1", outs(), 5'b11100);
    rst_n = 1'b0;
    #2;
    check("R1", outs(), 5'b10000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", outs(), 5'b10000);
    // R1: transmit DMA enabled on a flag that reset left set gives no request.
    drive({6'b000000, 4'b0000, 6'b100010});
    @(posedge clk);
    #2;
    check("R1", outs(), 5'b00000);
    @(negedge clk);
    // R7: the next empty edge after a write does pulse.
    drive({6'b000000, 4'b1000, 6'b100010});
    @(negedge clk);
    drive({6'b100000, 4'b0000, 6'b100010});
    @(posedge clk);
    #2;
    check("R7", outs(), 5'b00010);
    @(negedge clk);
    drive(16'h0000);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule